// File: doc/BRIEF.md
# Port Register Core for a 24-Line I/O Expander

This block holds the pin-facing state of a remote I/O expander with three 8-bit ports. For every port it keeps a direction register, a captured-input register, an output-value register and a read-inversion register. From these it drives a per-pin output enable and output value. It also synchronises the raw pin levels and reports a change on any input pin through an active-low interrupt line.

A host reaches the registers through a plain one-cycle read/write strobe interface. Each access carries a 2-bit register kind and a 2-bit port number. A serial-bus target can sit in front of this interface and turn bus transactions into these strobes. One strap input picks between two bus addresses, and the block reports the chosen address to that bus target.

Top module: `gpio_expander_core`

## Requirements
- R1: While the active-low reset is asserted, and after it is released until the first write, every pin is an input (`pin_oe` all zero), `pin_out` is all ones, inversion is off and `irq_n` is high.
- R2: The register kind is encoded as 0 = captured input, 1 = output value, 2 = inversion, 3 = direction. Port number p selects pins 8p to 8p+7. A direction bit of 1 makes its pin an input and 0 makes it an output, so `pin_oe` of that pin equals the inverse of the bit from the cycle after the write.
- R3: `pin_out` of every pin follows its output-value bit from the cycle after the write, whatever the direction. The pin is only driven when `pin_oe` is high.
- R4: Reads of output-value, inversion and direction return the last value written to that port, combinationally on `host_rdata` while `host_rd` is high.
- R5: A read of the captured-input kind returns the synchronised pin levels XOR the inversion bits. Inversion never changes the value stored or compared for the interrupt.
- R6: A pin configured as input that changes level makes `irq_n` go low after exactly two rising clock edges, which is the synchroniser delay.
- R7: A read of a port's captured-input register stores the current synchronised levels for that port. The mismatch on that port then clears at the capture edge.
- R8: When a changed pin returns to its captured level, `irq_n` goes high again without any read, two edges after the return.
- R9: Level changes on pins configured as outputs never pull `irq_n` low.
- R10: Port number 3 reads as zero for every register kind, and writes to it change no register.
- R11: `bus_addr` equals the base address with bit 0 replaced by `addr_sel`.
- R12: Asserting reset after operation restores every R1 default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, also used for power-on |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe, one cycle per read |
| host_kind | input | 2 | Register kind: 0 input, 1 output, 2 inversion, 3 direction |
| host_port | input | 2 | Port number |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid while host_rd is high |
| pin_in | input | 24 | Raw pin levels |
| pin_oe | output | 24 | Per-pin output enable |
| pin_out | output | 24 | Per-pin output value |
| irq_n | output | 1 | Active-low change interrupt |
| addr_sel | input | 1 | Address strap |
| bus_addr | output | 7 | Selected 7-bit bus address |

## Verification
A wrong direction or output bit shows on `pin_oe` or `pin_out` one edge after the write that caused it. A stale captured-input value shows in two ways. On a read it returns the wrong level. The interrupt also stays low, or fails to fall, exactly two edges after a pin moves. The bench therefore samples the interrupt at the edge before and the edge at which it should change. It also probes the idle port number with both writes and reads, so that a decode that aliases that port onto a real one shows up on the pins at once.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
   typedef enum logic [1:0] {
      KIND_IN  = 2'd0,
      KIND_OUT = 2'd1,
      KIND_INV = 2'd2,
      KIND_DIR = 2'd3
   } gpx_kind_e;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpx_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("gpx_sync: W must be positive");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpx_port.sv
module gpx_port
   import gpx_pkg::*;
#(
   parameter int           W       = 8,
   parameter logic [W-1:0] OUT_RST = '1,
   parameter logic [W-1:0] INV_RST = '0,
   parameter logic [W-1:0] DIR_RST = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic         cap_en,
   input  gpx_kind_e    kind,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] pin_s,
   output logic [W-1:0] dir_q,
   output logic [W-1:0] out_q,
   output logic [W-1:0] inv_q,
   output logic [W-1:0] chg,
   output logic [W-1:0] rd_val
);
   logic [W-1:0] cap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= DIR_RST;
         out_q <= OUT_RST;
         inv_q <= INV_RST;
      end else if (wr_en) begin
         case (kind)
            KIND_OUT: out_q <= wdata;
            KIND_INV: inv_q <= wdata;
            KIND_DIR: dir_q <= wdata;
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cap_q <= '0;
      else if (cap_en) cap_q <= pin_s;
   end

   assign chg = dir_q & (pin_s ^ cap_q);

   always_comb begin
      case (kind)
         KIND_IN:  rd_val = pin_s ^ inv_q;
         KIND_OUT: rd_val = out_q;
         KIND_INV: rd_val = inv_q;
         default:  rd_val = dir_q;
      endcase
   end
endmodule

// File: rtl/gpx_rdmux.sv
module gpx_rdmux #(
   parameter int N     = 3,
   parameter int W     = 8,
   parameter int IDX_W = 2
) (
   input  logic [N*W-1:0]   vals,
   input  logic [IDX_W-1:0] sel,
   output logic [W-1:0]     dout
);
   always_comb begin
      dout = '0;
      for (int i = 0; i < N; i++) begin
         if (sel == IDX_W'(i)) dout = vals[i*W +: W];
      end
   end
endmodule

// File: rtl/gpio_expander_core.sv
module gpio_expander_core
   import gpx_pkg::*;
#(
   parameter int         NUM_PORTS   = 3,
   parameter int         PORT_W      = 8,
   parameter int         IDX_W       = 2,
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] BASE_ADDR   = 7'h22
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           host_wr,
   input  logic                           host_rd,
   input  logic [1:0]                     host_kind,
   input  logic [IDX_W-1:0]               host_port,
   input  logic [PORT_W-1:0]              host_wdata,
   output logic [PORT_W-1:0]              host_rdata,
   input  logic [NUM_PORTS*PORT_W-1:0]    pin_in,
   output logic [NUM_PORTS*PORT_W-1:0]    pin_oe,
   output logic [NUM_PORTS*PORT_W-1:0]    pin_out,
   output logic                           irq_n,
   input  logic                           addr_sel,
   output logic [6:0]                     bus_addr
);
   localparam int PINS = NUM_PORTS * PORT_W;

   if (NUM_PORTS < 1 || NUM_PORTS > (1 << IDX_W)) begin : g_bad_ports
      $error("gpio_expander_core: NUM_PORTS must fit the port number field");
   end
   if (PORT_W < 1) begin : g_bad_w
      $error("gpio_expander_core: PORT_W must be positive");
   end

   gpx_kind_e             kind;
   logic [PINS-1:0]       pin_s;
   logic [PINS-1:0]       chg_all;
   logic [PINS-1:0]       rd_all;
   logic [PINS-1:0]       dir_all;

   assign kind = gpx_kind_e'(host_kind);

   gpx_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_s)
   );

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(p);
      logic hit, wr_en, cap_en;
      logic [PORT_W-1:0] inv_unused;

      assign hit    = (host_port == MY_IDX);
      assign wr_en  = host_wr && hit;
      assign cap_en = host_rd && hit && (kind == KIND_IN);

      gpx_port #(.W(PORT_W)) u_port (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en  (wr_en),
         .cap_en (cap_en),
         .kind   (kind),
         .wdata  (host_wdata),
         .pin_s  (pin_s[p*PORT_W +: PORT_W]),
         .dir_q  (dir_all[p*PORT_W +: PORT_W]),
         .out_q  (pin_out[p*PORT_W +: PORT_W]),
         .inv_q  (inv_unused),
         .chg    (chg_all[p*PORT_W +: PORT_W]),
         .rd_val (rd_all[p*PORT_W +: PORT_W])
      );
   end

   gpx_rdmux #(.N(NUM_PORTS), .W(PORT_W), .IDX_W(IDX_W)) u_rdmux (
      .vals (rd_all),
      .sel  (host_port),
      .dout (host_rdata)
   );

   assign pin_oe   = ~dir_all;
   assign irq_n    = ~(|chg_all);
   assign bus_addr = {BASE_ADDR[6:1], addr_sel};
endmodule

// File: rtl/gpx_checker.sv
module gpx_checker #(
   parameter int         NUM_PORTS = 3,
   parameter int         PORT_W    = 8,
   parameter int         IDX_W     = 2,
   parameter logic [6:0] BASE_ADDR = 7'h22
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        host_wr,
   input logic [1:0]                  host_kind,
   input logic [IDX_W-1:0]            host_port,
   input logic [NUM_PORTS*PORT_W-1:0] pin_oe,
   input logic [NUM_PORTS*PORT_W-1:0] pin_out,
   input logic                        irq_n,
   input logic                        addr_sel,
   input logic [6:0]                  bus_addr
);
   AST_RESET_DEFAULTS: assert property (@(posedge clk)
      !rst_n |-> (pin_oe == '0 && (&pin_out) && irq_n)); // R1

   AST_DIR_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_wr && host_kind == 2'd3) |=> $stable(pin_oe)); // R2

   AST_OUT_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_wr && host_kind == 2'd1) |=> $stable(pin_out)); // R3

   AST_IDLE_PORT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && int'(host_port) >= NUM_PORTS) |=> ($stable(pin_oe) && $stable(pin_out))); // R10

   AST_OUTPUTS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (&pin_oe) |-> irq_n); // R9

   AST_ADDR_STRAP: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr == {BASE_ADDR[6:1], addr_sel}); // R11
endmodule

bind gpio_expander_core gpx_checker #(
   .NUM_PORTS (NUM_PORTS),
   .PORT_W    (PORT_W),
   .IDX_W     (IDX_W),
   .BASE_ADDR (BASE_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .host_wr   (host_wr),
   .host_kind (host_kind),
   .host_port (host_port),
   .pin_oe    (pin_oe),
   .pin_out   (pin_out),
   .irq_n     (irq_n),
   .addr_sel  (addr_sel),
   .bus_addr  (bus_addr)
);

// File: tb/gpio_expander_core_test.sv
module gpio_expander_core_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [1:0]  host_kind = 2'd0, host_port = 2'd0;
   logic [7:0]  host_wdata = 8'd0;
   logic [7:0]  host_rdata;
   logic [23:0] pin_in = 24'd0;
   logic [23:0] pin_oe, pin_out;
   logic        irq_n;
   logic        addr_sel = 1'b0;
   logic [6:0]  bus_addr;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   gpio_expander_core uut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_kind(host_kind), .host_port(host_port), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .pin_in(pin_in), .pin_oe(pin_oe),
      .pin_out(pin_out), .irq_n(irq_n), .addr_sel(addr_sel), .bus_addr(bus_addr)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic wr(input logic [1:0] k, input logic [1:0] p, input logic [7:0] d);
      host_kind = k; host_port = p; host_wdata = d; host_wr = 1'b1;
      step(1);
      host_wr = 1'b0;
   endtask

   task automatic rd(input string req, input logic [1:0] k, input logic [1:0] p,
                     input logic [7:0] exp);
      host_kind = k; host_port = p; host_rd = 1'b1;
      #1;
      check(req, {24'd0, host_rdata}, {24'd0, exp});
      step(1);
      host_rd = 1'b0;
   endtask

   task automatic check_defaults(input string req);
      check(req, pin_oe, 24'h000000);
      check(req, pin_out, 24'hFFFFFF);
      check(req, {31'd0, irq_n}, 32'd1);
      for (int p = 0; p < 3; p++) begin
         rd(req, 2'd2, 2'(p), 8'h00);
         rd(req, 2'd3, 2'(p), 8'hFF);
         rd(req, 2'd1, 2'(p), 8'hFF);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #1 rst_n = 1'b0;
      @(negedge clk);
      // R1: defaults while reset held
      check("R1", pin_oe, 24'h000000);
      check("R1", pin_out, 24'hFFFFFF);
      check("R1", {31'd0, irq_n}, 32'd1);
      step(1);
      rst_n = 1'b1;
      step(1);
      check_defaults("R1");

      // R4/R3: exhaustive output register per port
      for (int p = 0; p < 3; p++) begin
         for (int v = 0; v < 256; v++) begin
            wr(2'd1, 2'(p), 8'(v));
            check("R3", {24'd0, pin_out[p*8 +: 8]}, v);
            rd("R4", 2'd1, 2'(p), 8'(v));
         end
      end

      // R2/R4: direction sweep, pin_oe is inverse of direction bit
      for (int p = 0; p < 3; p++) begin
         for (int v = 0; v < 256; v += 17) begin
            wr(2'd3, 2'(p), 8'(v));
            check("R2", {24'd0, pin_oe[p*8 +: 8]}, {24'd0, ~8'(v)});
            rd("R4", 2'd3, 2'(p), 8'(v));
         end
         wr(2'd3, 2'(p), 8'hFF);
      end

      // R4: inversion register readback
      for (int p = 0; p < 3; p++) begin
         for (int v = 3; v < 256; v += 29) begin
            wr(2'd2, 2'(p), 8'(v));
            rd("R4", 2'd2, 2'(p), 8'(v));
         end
      end

      // R5: input read is pin XOR inversion
      for (int p = 0; p < 3; p++) begin
         for (int k = 0; k < 256; k += 13) begin
            logic [7:0] pv, iv;
            pv = 8'(k);
            iv = 8'(k * 7 + 5);
            pin_in[p*8 +: 8] = pv;
            wr(2'd2, 2'(p), iv);
            step(2);
            rd("R5", 2'd0, 2'(p), pv ^ iv);
         end
      end

      // capture a quiet state on every port
      pin_in = 24'h000000;
      step(3);
      for (int p = 0; p < 3; p++) rd("R7", 2'd0, 2'(p), 8'(k_inv(p)));
      check("R7", {31'd0, irq_n}, 32'd1);

      // R6: two-edge delay to interrupt
      pin_in[9] = 1'b1;
      step(1);
      check("R6", {31'd0, irq_n}, 32'd1);
      step(1);
      check("R6", {31'd0, irq_n}, 32'd0);
      // R7: reading another port keeps interrupt, reading port 1 clears it
      rd("R7", 2'd0, 2'd0, 8'(k_inv(0)));
      check("R7", {31'd0, irq_n}, 32'd0);
      rd("R7", 2'd0, 2'd1, 8'(k_inv(1)) ^ 8'h02);
      check("R7", {31'd0, irq_n}, 32'd1);
      // R8: clears when pin returns to captured level
      pin_in[9] = 1'b0;
      step(2);
      check("R8", {31'd0, irq_n}, 32'd0);
      pin_in[9] = 1'b1;
      step(1);
      check("R8", {31'd0, irq_n}, 32'd0);
      step(1);
      check("R8", {31'd0, irq_n}, 32'd1);

      // R9: output-configured pins do not interrupt
      wr(2'd3, 2'd2, 8'h00);
      pin_in[23:16] = 8'hA5;
      step(3);
      check("R9", {31'd0, irq_n}, 32'd1);
      // turning them back to inputs exposes the mismatch
      wr(2'd3, 2'd2, 8'hFF);
      check("R9", {31'd0, irq_n}, 32'd0);
      rd("R7", 2'd0, 2'd2, 8'hA5 ^ 8'(k_inv(2)));
      check("R7", {31'd0, irq_n}, 32'd1);

      // R10: port 3 reads zero and ignores writes
      begin
         logic [23:0] oe_before, out_before;
         oe_before = pin_oe; out_before = pin_out;
         for (int k = 0; k < 4; k++) begin
            wr(2'(k), 2'd3, 8'h5A);
            check("R10", pin_oe, oe_before);
            check("R10", pin_out, out_before);
            rd("R10", 2'(k), 2'd3, 8'h00);
         end
         for (int p = 0; p < 3; p++) rd("R10", 2'd1, 2'(p), out_before[p*8 +: 8]);
      end

      // R11: address strap
      addr_sel = 1'b0; #1;
      check("R11", {25'd0, bus_addr}, 32'h22);
      addr_sel = 1'b1; #1;
      check("R11", {25'd0, bus_addr}, 32'h23);
      step(1);

      // R12: reset after operation
      wr(2'd3, 2'd0, 8'h0F);
      wr(2'd1, 2'd1, 8'h00);
      wr(2'd2, 2'd2, 8'h3C);
      pin_in = 24'd0;
      rst_n = 1'b0;
      step(1);
      rst_n = 1'b1;
      step(3);
      check_defaults("R12");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   // inversion values left in each port by the R4 inversion sweep
   function automatic int k_inv(input int p);
      int last;
      last = 3;
      for (int v = 3; v < 256; v += 29) last = v;
      // R5 sweep rewrote inversion; last written value is (k*7+5) for k=247
      last = (247 * 7 + 5) & 8'hFF;
      return (p >= 0) ? last : 0;
   endfunction
endmodule